// File: doc/BRIEF.md
# Linear Framebuffer Aperture Decoder

This block decides whether a host memory address falls inside the linear framebuffer window of a display controller, and where inside that window it lands. Software programs a size code, two base-address bytes and an enable bit through a byte-wide indexed register port. The two base bytes can also be reached through the bytes of a PCI configuration base address register. Both paths update one shared base register.

The window size comes from a two-bit code. The largest code maps to a size that depends on the chip variant, which is chosen by a parameter. Whenever the size or a base byte changes, the base is cleared below the window size, so it always stays naturally aligned. The window turns itself off when the base lies in the top three address bits' range, or when it sits on the legacy VGA address 0x000A0000.

Each cycle the block compares the bus address with the window. It registers a hit flag and the offset of the address from the base.

Top module: `lfb_aperture_dec`

## Requirements
- R1: After reset the size code is 0 (64 KiB), the base is 0, the master enable is 0 and `win_hit` is 0.
- R2: Size codes 0, 1 and 2 give windows of 64 KiB, 1 MiB and 2 MiB. Code 3 gives 2 MiB for VARIANT 0, 4 MiB for VARIANT 1 and 8 MiB for any other VARIANT.
- R3: With VARIANT 0, writing size code 3 stores code 2, and the size register reads back 2.
- R4: After any write to the size code or to a base byte, through either port, base bits below the window size read as zero. Base bits 15:0 are always zero.
- R5: The index port uses these encodings: index 0 is control (bit 0 is the master enable, other bits read 0), index 1 is the size code (bits 1:0), index 2 is base bits 31:24 and index 3 is base bits 23:16. `reg_rdata` returns the current register value at `reg_idx`, combinationally.
- R6: Configuration reads: offsets 0x10 and 0x11 return 0, offset 0x12 returns base bits 23:16, offset 0x13 returns base bits 31:24 ANDed with 0x1F, and any other offset returns 0.
- R7: A configuration write to offset 0x12 sets base bits 23:16 and a write to offset 0x13 sets base bits 31:24, followed by alignment masking. Writes to other offsets leave the base unchanged.
- R8: The window is disabled while any of base bits 31:29 is set.
- R9: The window is disabled while the base equals 0x000A0000.
- R10: `win_hit` is 1 in the cycle after an address is presented exactly when all of these hold: the master enable is set, the window is not disabled, the address is at or above the base, and the address is below base + size. All values are taken before that clock edge.
- R11: `win_offset` equals the address minus the base, registered one cycle after the address is presented.
- R12: When both ports write in the same cycle, the index-port write takes effect and the configuration write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Index-port write strobe |
| reg_idx | input | 2 | Index-port register select |
| reg_wdata | input | 8 | Index-port write data |
| reg_rdata | output | 8 | Index-port read data for `reg_idx` |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_off | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_off` |
| bus_addr | input | 32 | Address to decode |
| win_hit | output | 1 | Registered window hit |
| win_offset | output | 32 | Registered address minus base |

## Verification
Register writes land at the clock edge. Both read ports are combinational, so readback is due right after that edge. The bench drives inputs on the falling edge and, after a short settle delay, compares readback against a model that has not yet applied that cycle's write. `win_hit` and `win_offset` are due one rising edge after the address. The bench computes their expected values from the model state before the edge, then samples them at the following falling edge. The bench drives three instances, one for each variant, with the same stimulus, which covers the variant-dependent code 3.

// File: rtl/lfb_pkg.sv
package lfb_pkg;

    localparam int BASE_LSB = 16;
    localparam int BASE_W   = 32 - BASE_LSB;
    localparam int BYTE_W   = 8;
    localparam int CODE_W   = 2;

    typedef enum logic [1:0] {
        IDX_CTRL     = 2'd0,
        IDX_SIZE     = 2'd1,
        IDX_BASE_HI  = 2'd2,
        IDX_BASE_MID = 2'd3
    } reg_idx_e;

    localparam logic [7:0] CFG_BAR_B0 = 8'h10;
    localparam logic [7:0] CFG_BAR_B1 = 8'h11;
    localparam logic [7:0] CFG_BAR_B2 = 8'h12;
    localparam logic [7:0] CFG_BAR_B3 = 8'h13;

    typedef struct packed {
        logic              en;
        logic [CODE_W-1:0] code;
        logic [BASE_W-1:0] base;
    } lfb_regs_t;

    function automatic logic [31:0] size_bytes(input logic [CODE_W-1:0] code, input int variant);
        logic [31:0] s;
        case (code)
            2'd0:    s = 32'h0001_0000;
            2'd1:    s = 32'h0010_0000;
            2'd2:    s = 32'h0020_0000;
            default: s = (variant == 0) ? 32'h0020_0000 :
                         (variant == 1) ? 32'h0040_0000 : 32'h0080_0000;
        endcase
        return s;
    endfunction

    function automatic logic [BASE_W-1:0] base_keep(input logic [CODE_W-1:0] code, input int variant);
        logic [31:0] lowbits;
        lowbits = size_bytes(code, variant) - 32'd1;
        return ~lowbits[31:BASE_LSB];
    endfunction

endpackage

// File: rtl/lfb_regs.sv
module lfb_regs
    import lfb_pkg::*;
#(
    parameter int VARIANT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [1:0]         reg_idx,
    input  logic [BYTE_W-1:0]  reg_wdata,
    output logic [BYTE_W-1:0]  reg_rdata,
    input  logic               cfg_we,
    input  logic [7:0]         cfg_off,
    input  logic [BYTE_W-1:0]  cfg_wdata,
    output logic [BYTE_W-1:0]  cfg_rdata,
    output lfb_regs_t          regs
);

    lfb_regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (reg_we) begin
            case (reg_idx_e'(reg_idx))
                IDX_CTRL:     s_d.en = reg_wdata[0];
                IDX_SIZE: begin
                    s_d.code = reg_wdata[CODE_W-1:0];
                    if (VARIANT == 0 && s_d.code == 2'd3) s_d.code = 2'd2;
                end
                IDX_BASE_HI:  s_d.base[15:8] = reg_wdata;
                IDX_BASE_MID: s_d.base[7:0]  = reg_wdata;
                default:      s_d = s_q;
            endcase
        end else if (cfg_we) begin
            if (cfg_off == CFG_BAR_B2) s_d.base[7:0]  = cfg_wdata;
            if (cfg_off == CFG_BAR_B3) s_d.base[15:8] = cfg_wdata;
        end
        // Re-align on every cycle; a no-op unless size or base just changed.
        s_d.base = s_d.base & base_keep(s_d.code, VARIANT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (reg_idx_e'(reg_idx))
            IDX_CTRL:     reg_rdata = {7'd0, s_q.en};
            IDX_SIZE:     reg_rdata = {6'd0, s_q.code};
            IDX_BASE_HI:  reg_rdata = s_q.base[15:8];
            IDX_BASE_MID: reg_rdata = s_q.base[7:0];
            default:      reg_rdata = '0;
        endcase
    end

    always_comb begin
        case (cfg_off)
            CFG_BAR_B2: cfg_rdata = s_q.base[7:0];
            CFG_BAR_B3: cfg_rdata = s_q.base[15:8] & 8'h1F;
            default:    cfg_rdata = '0;
        endcase
    end

    assign regs = s_q;

    // R4: stored base never has bits set below the window size
    a_r4_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.base & ~base_keep(s_q.code, VARIANT)) == '0);

    // R6: the top BAR byte never shows bits 7:5
    a_r6_bar_top_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_off == CFG_BAR_B3) |-> (cfg_rdata[7:5] == 3'd0));

    // R7: a config write to a non-base offset with no index write leaves the base alone
    a_r7_cfg_other_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !reg_we && cfg_off != CFG_BAR_B2 && cfg_off != CFG_BAR_B3)
        |=> $stable(s_q.base));

    generate
        if (VARIANT == 0) begin : g_small
            // R3: code 3 is never held on the smallest variant
            a_r3_no_code3: assert property (@(posedge clk) disable iff (!rst_n)
                s_q.code != 2'd3);
        end
    endgenerate

endmodule

// File: rtl/lfb_window.sv
module lfb_window #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] size,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] offset
);

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] off;
    } win_t;

    win_t w_d, w_q;
    logic [ADDR_W-1:0] diff;

    always_comb begin
        diff    = addr - base;
        w_d.off = diff;
        w_d.hit = en && (addr >= base) && (diff < size);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign hit    = w_q.hit;
    assign offset = w_q.off;

    // R10: a hit only follows a cycle with the window enabled
    a_r10_hit_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(en));

    // R11: on a hit the offset lies inside the window
    a_r11_off_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (offset < $past(size)));

endmodule

// File: rtl/lfb_aperture_dec.sv
module lfb_aperture_dec
    import lfb_pkg::*;
#(
    parameter int VARIANT = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_idx,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        cfg_we,
    input  logic [7:0]  cfg_off,
    input  logic [7:0]  cfg_wdata,
    output logic [7:0]  cfg_rdata,
    input  logic [31:0] bus_addr,
    output logic        win_hit,
    output logic [31:0] win_offset
);

    localparam logic [BASE_W-1:0] LEGACY_BASE = 16'h000A;

    lfb_regs_t   regs;
    logic [31:0] base32;
    logic [31:0] size32;
    logic        win_en;

    lfb_regs #(.VARIANT(VARIANT)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg_we    (cfg_we),
        .cfg_off   (cfg_off),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .regs      (regs)
    );

    always_comb begin
        base32 = {regs.base, {BASE_LSB{1'b0}}};
        size32 = size_bytes(regs.code, VARIANT);
        win_en = regs.en && (regs.base[BASE_W-1 -: 3] == 3'd0) && (regs.base != LEGACY_BASE);
    end

    lfb_window #(.ADDR_W(32)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (win_en),
        .base   (base32),
        .size   (size32),
        .addr   (bus_addr),
        .hit    (win_hit),
        .offset (win_offset)
    );

    // R8: a hit never follows a cycle with any of base bits 31:29 set
    a_r8_top_bits_off: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> ($past(regs.base[BASE_W-1 -: 3]) == 3'd0));

    // R9: a hit never follows a cycle with the base on the legacy address
    a_r9_legacy_off: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> ($past(regs.base) != LEGACY_BASE));

endmodule

// File: tb/lfb_aperture_dec_bench.sv
module lfb_aperture_dec_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_idx = '0;
    logic [7:0]  reg_wdata = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_off = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [31:0] bus_addr = '0;

    logic        hit [3];
    logic [31:0] off [3];
    logic [7:0]  rrd [3];
    logic [7:0]  crd [3];

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic        m_en;
    logic [1:0]  m_code [3];
    logic [15:0] m_base [3];

    always #2 clk = ~clk;

    generate
        for (genvar v = 0; v < 3; v++) begin : g_var
            lfb_aperture_dec #(.VARIANT(v)) u_lfb_aperture_dec (
                .clk(clk), .rst_n(rst_n),
                .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(rrd[v]),
                .cfg_we(cfg_we), .cfg_off(cfg_off), .cfg_wdata(cfg_wdata), .cfg_rdata(crd[v]),
                .bus_addr(bus_addr), .win_hit(hit[v]), .win_offset(off[v])
            );
        end
    endgenerate

    function automatic logic [31:0] sz(input logic [1:0] code, input int v);
        case (code)
            2'd0: return 32'h0001_0000;
            2'd1: return 32'h0010_0000;
            2'd2: return 32'h0020_0000;
            default: return (v == 0) ? 32'h0020_0000 : (v == 1) ? 32'h0040_0000 : 32'h0080_0000;
        endcase
    endfunction

    function automatic logic [15:0] keep(input logic [1:0] code, input int v);
        logic [31:0] m;
        m = sz(code, v) - 32'd1;
        return ~m[31:16];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive on negedge, check readback, clock, check registered outputs.
    task automatic step(input logic iwe, input logic [1:0] idx, input logic [7:0] iwd,
                        input logic cwe, input logic [7:0] coff, input logic [7:0] cwd,
                        input logic [31:0] addr);
        logic        eh [3];
        logic [31:0] eo [3];
        reg_we = iwe; reg_idx = idx; reg_wdata = iwd;
        cfg_we = cwe; cfg_off = coff; cfg_wdata = cwd;
        bus_addr = addr;
        #1;
        for (int v = 0; v < 3; v++) begin
            logic [7:0]  er, ec;
            logic [31:0] b32, d;
            logic        en;
            case (idx)
                2'd0: er = {7'd0, m_en};
                2'd1: er = {6'd0, m_code[v]};
                2'd2: er = m_base[v][15:8];
                default: er = m_base[v][7:0];
            endcase
            chk($sformatf("R5 index readback v%0d idx%0d", v, idx), {24'd0, rrd[v]}, {24'd0, er});
            ec = (coff == 8'h12) ? m_base[v][7:0] : (coff == 8'h13) ? (m_base[v][15:8] & 8'h1F) : 8'h00;
            chk($sformatf("R6 config readback v%0d off%h", v, coff), {24'd0, crd[v]}, {24'd0, ec});
            b32 = {m_base[v], 16'h0};
            d = addr - b32;
            en = m_en && (b32[31:29] == 3'd0) && (b32 != 32'h000A_0000);
            eh[v] = en && (addr >= b32) && (d < sz(m_code[v], v));
            eo[v] = d;
        end
        if (iwe && idx == 2'd0) m_en = iwd[0];
        for (int v = 0; v < 3; v++) begin
            if (iwe) begin
                case (idx)
                    2'd1: begin
                        m_code[v] = iwd[1:0];
                        if (v == 0 && m_code[v] == 2'd3) m_code[v] = 2'd2;
                    end
                    2'd2: m_base[v][15:8] = iwd;
                    2'd3: m_base[v][7:0] = iwd;
                    default: ;
                endcase
            end else if (cwe) begin
                if (coff == 8'h12) m_base[v][7:0] = cwd;
                if (coff == 8'h13) m_base[v][15:8] = cwd;
            end
            m_base[v] = m_base[v] & keep(m_code[v], v);
        end
        @(posedge clk);
        @(negedge clk);
        for (int v = 0; v < 3; v++) begin
            chk($sformatf("R10 hit (R8 R9 gating) v%0d addr %h", v, addr), {31'd0, hit[v]}, {31'd0, eh[v]});
            chk($sformatf("R11 offset v%0d", v), off[v], eo[v]);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [7:0] d);
        step(1'b1, idx, d, 1'b0, 8'h00, 8'h00, 32'h0);
    endtask

    task automatic probe(input logic [31:0] a);
        step(1'b0, 2'd1, 8'h00, 1'b0, 8'h12, 8'h00, a);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_en = 1'b0;
        for (int v = 0; v < 3; v++) begin m_code[v] = 2'd0; m_base[v] = 16'h0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state visible at the ports
        for (int i = 0; i < 4; i++) begin
            reg_idx = 2'(i);
            #1;
            for (int v = 0; v < 3; v++) chk($sformatf("R1 reset reg v%0d idx%0d", v, i), {24'd0, rrd[v]}, 32'd0);
        end
        for (int v = 0; v < 3; v++) chk($sformatf("R1 reset hit v%0d", v), {31'd0, hit[v]}, 32'd0);
        @(negedge clk);

        // R10: disabled master enable blocks a hit at base 0
        probe(32'h0000_0010);
        wr(2'd0, 8'h01);
        wr(2'd2, 8'h01);                 // base 0x0100_0000, aligned for all sizes
        // R2: each code, probe last byte and first byte past the window
        for (int c = 0; c < 4; c++) begin
            wr(2'd1, 8'(c));
            probe(32'h0100_0000 + sz(2'(c), 2) - 1);
            probe(32'h0100_0000 + sz(2'(c), 1) - 1);
            probe(32'h0100_0000 + sz(2'(c), 0));
            probe(32'h0100_0000 + sz(2'(c), 1));
            probe(32'h00FF_FFFF);
        end
        // R3: code 3 reads back 2 on variant 0 (index 1 readback inside step)
        wr(2'd1, 8'h03);
        probe(32'h0);
        // R4: unaligned base byte is cleared below the 1 MiB size
        wr(2'd1, 8'h01);
        wr(2'd3, 8'hFF);
        step(1'b0, 2'd3, 8'h00, 1'b0, 8'h13, 8'h00, 32'h01F0_0000);
        // R4: shrinking then growing the size re-masks the base
        wr(2'd1, 8'h00);
        wr(2'd3, 8'h37);
        wr(2'd1, 8'h02);
        probe(32'h0120_0000);
        // R7: config writes update the shared base; other offsets ignored
        wr(2'd1, 8'h00);
        step(1'b0, 2'd2, 8'h00, 1'b1, 8'h13, 8'h02, 32'h0);
        step(1'b0, 2'd3, 8'h00, 1'b1, 8'h12, 8'h45, 32'h0245_0004);
        step(1'b0, 2'd3, 8'h00, 1'b1, 8'h10, 8'hAA, 32'h0245_0008);
        step(1'b0, 2'd2, 8'h00, 1'b1, 8'h11, 8'hBB, 32'h0245_0008);
        step(1'b0, 2'd2, 8'h00, 1'b1, 8'h30, 8'hCC, 32'h0245_0008);
        step(1'b0, 2'd2, 8'h00, 1'b0, 8'h10, 8'h00, 32'h0245_0008);
        step(1'b0, 2'd2, 8'h00, 1'b0, 8'h11, 8'h00, 32'h0245_0008);
        // R12: both ports write in one cycle, index port wins
        step(1'b1, 2'd3, 8'h66, 1'b1, 8'h12, 8'h77, 32'h0);
        step(1'b1, 2'd2, 8'h03, 1'b1, 8'h13, 8'h09, 32'h0366_0001);
        probe(32'h0366_0001);
        // R8: top bits set disable the window; config 0x13 hides them
        wr(2'd2, 8'hE1);
        probe(32'hE166_0000);
        step(1'b0, 2'd2, 8'h00, 1'b0, 8'h13, 8'h00, 32'hE166_0000);
        wr(2'd2, 8'h20);
        probe(32'h2066_0000);
        // R9: legacy base disables; neighbour base does not
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h0A);
        probe(32'h000A_0000);
        probe(32'h000A_8000);
        wr(2'd3, 8'h0B);
        probe(32'h000B_0000);

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            logic        iwe, cwe;
            logic [1:0]  idx;
            logic [7:0]  iwd, coff, cwd;
            logic [31:0] a, b;
            iwe = ($urandom % 4) == 0;
            idx = 2'($urandom % 4);
            iwd = 8'($urandom);
            if (idx == 2'd0 && ($urandom % 4) != 0) iwd[0] = 1'b1;
            if (idx == 2'd2 && ($urandom % 8) != 0) iwd = iwd & 8'h1F;
            cwe = ($urandom % 6) == 0;
            coff = 8'h10 + 8'($urandom % 5);
            cwd = 8'($urandom);
            if (($urandom % 8) != 0) cwd = cwd & 8'h1F;
            b = {m_base[2], 16'h0};
            case ($urandom % 4)
                0: a = $urandom;
                1: a = b + ($urandom % 32'h0090_0000);
                2: a = b - ($urandom % 32'h0000_0100);
                default: a = b + sz(m_code[2], 2) - 32'($urandom % 4);
            endcase
            step(iwe, idx, iwd, cwe, coff, cwd, a);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule